// File: doc/BRIEF.md
# Partitioned SIMD Leading-Sign-Bit Counter

This unit treats a 128-bit operand as a row of independent lanes and reports, for every lane, how long the run of copies of the lane's sign bit is directly beneath that sign bit. The sign bit itself is not part of the count. Each count is zero-extended and written back into the result at the same place and width as the lane it came from. A 2-bit size code selects 8-, 16- or 32-bit lanes. A width select limits the active data to the low 64 bits or opens it to all 128 bits. The fourth size code is reserved: it raises an undefined flag and produces no valid result.

The counting fabric is purely combinational. A parameter chooses whether an output register with a small three-state controller follows it. With the register present, an input strobe is answered exactly one clock later. The controller sits in ST_IDLE when nothing was presented on the previous clock. It moves to ST_VALID when a legal size code was strobed, and to ST_UNDEF when the reserved code was strobed. Every state can reach every other state on any clock, depending only on the current strobe and size code. The result register loads only on the move into ST_VALID; in all other cases it keeps its value.

Top module: `lsc_vec_top`

## Requirements
- R1: For each lane, the count equals the number of consecutive bits directly below the lane's top bit that equal the top bit; the top bit is never counted.
- R2: Size code 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Lane 0 occupies the least significant bits, and lane numbers rise toward the most significant bits.
- R3: A lane that is all zeros or all ones yields its width minus one (7, 15 or 31).
- R4: Each count is zero-extended and placed in the result lane with the same position and width as its source lane.
- R5: With `full_width`=0, only the lanes in bits 63:0 are processed, and result bits 127:64 are zero. With `full_width`=1, all 128 bits are processed.
- R6: A strobe with size code 2'b11 sets `undef` high and `out_valid` low on the next clock, and leaves `result` unchanged.
- R7: A strobe with a legal size code sets `out_valid` high and loads `result` on the next clock, exactly one cycle after the strobe.
- R8: A clock with `in_valid` low sets both `out_valid` and `undef` low after that edge, and leaves `result` unchanged.
- R9: While reset is asserted and directly after it, `out_valid`=0, `undef`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking an operand to process |
| operand | input | 128 | Vector operand split into lanes |
| size_code | input | 2 | Lane width code: 00=8, 01=16, 10=32, 11=reserved |
| full_width | input | 1 | 0: active width 64 bits, 1: active width 128 bits |
| out_valid | output | 1 | Result valid, one clock after a legal strobe |
| undef | output | 1 | Reserved size code seen, one clock after the strobe |
| result | output | 128 | Per-lane counts, zero-extended in place |

## Verification
A controller stuck in the wrong state shows on the clock after the next strobe. In that case `out_valid` and `undef` disagree with the size code that was presented, or one of them stays high through an idle cycle. A wrong lane split or a faulty per-lane count shows in the very next result word, as a lane value that differs from a scan of the operand bits. The lanes most likely to expose it are those holding runs of length zero or length width-minus-one. A result register that loads when it should hold shows as a changed `result` after a reserved or idle cycle.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } lsc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_VALID = 2'b01,
        ST_UNDEF = 2'b10
    } lsc_state_e;

    localparam int LSC_NUM_SIZES = 3;

endpackage

// File: rtl/lsc_lane.sv
module lsc_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out
);
    localparam int CNT_W = $clog2(LANE_W);

    logic [LANE_W-2:0] mismatch;
    logic [CNT_W-1:0]  run_len;
    logic              run_end;

    // Bits differing from the sign become 1; count the leading zeros of that map.
    always_comb begin
        mismatch = lane_in[LANE_W-2:0] ^ {(LANE_W-1){lane_in[LANE_W-1]}};
        run_len  = '0;
        run_end  = 1'b0;
        for (int i = LANE_W - 2; i >= 0; i--) begin
            if (!run_end) begin
                if (mismatch[i]) begin
                    run_end = 1'b1;
                end else begin
                    run_len = run_len + CNT_W'(1);
                end
            end
        end
        lane_out = '0;
        lane_out[CNT_W-1:0] = run_len;
    end
endmodule

// File: rtl/lsc_bank.sv
module lsc_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] vec_out
);
    localparam int N_LANES = VEC_W / LANE_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        lsc_lane #(.LANE_W(LANE_W)) u_lane (
            .lane_in  (vec_in [g*LANE_W +: LANE_W]),
            .lane_out (vec_out[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/lsc_out_stage.sv
module lsc_out_stage
    import lsc_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_ok,
    input  logic             take_rsv,
    input  logic [VEC_W-1:0] data_in,
    output logic             out_valid,
    output logic             undef,
    output logic [VEC_W-1:0] data_out
);
    lsc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = ST_IDLE;
        if (take_ok) begin
            state_d = ST_VALID;
        end else if (take_rsv) begin
            state_d = ST_UNDEF;
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        undef     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_VALID: out_valid = 1'b1;
            ST_UNDEF: undef     = 1'b1;
            default:  ;
        endcase
    end

    // Result register loads only on a legal strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
        end else if (take_ok) begin
            data_out <= data_in;
        end
    end

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take_ok |=> (out_valid && !undef && data_out == $past(data_in)));

    a_r6_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rsv && !take_ok) |=> (undef && !out_valid && $stable(data_out)));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_ok && !take_rsv) |=> (!out_valid && !undef && $stable(data_out)));
endmodule

// File: rtl/lsc_vec_top.sv
module lsc_vec_top
    import lsc_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int BASE_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] operand,
    input  logic [1:0]       size_code,
    input  logic             full_width,
    output logic             out_valid,
    output logic             undef,
    output logic [VEC_W-1:0] result
);
    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0] bank_res [LSC_NUM_SIZES];
    logic [VEC_W-1:0] comb_res;
    logic             is_rsvd;
    logic             take_ok;
    logic             take_rsv;

    // One bank per lane width: BASE_W, 2*BASE_W, 4*BASE_W
    for (genvar k = 0; k < LSC_NUM_SIZES; k++) begin : g_bank
        lsc_bank #(.VEC_W(VEC_W), .LANE_W(BASE_W << k)) u_bank (
            .vec_in  (operand),
            .vec_out (bank_res[k])
        );
    end

    always_comb begin
        comb_res = '0;
        is_rsvd  = 1'b0;
        unique case (lsc_size_e'(size_code))
            SZ_BYTE: comb_res = bank_res[0];
            SZ_HALF: comb_res = bank_res[1];
            SZ_WORD: comb_res = bank_res[2];
            SZ_RSVD: is_rsvd  = 1'b1;
            default: is_rsvd  = 1'b1;
        endcase
        if (!full_width) begin
            comb_res[VEC_W-1:HALF_W] = '0;
        end
    end

    assign take_ok  = in_valid && !is_rsvd;
    assign take_rsv = in_valid && is_rsvd;

    if (OUT_REG) begin : g_reg
        lsc_out_stage #(.VEC_W(VEC_W)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .take_ok   (take_ok),
            .take_rsv  (take_rsv),
            .data_in   (comb_res),
            .out_valid (out_valid),
            .undef     (undef),
            .data_out  (result)
        );

        a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !full_width && size_code != 2'b11)
                |=> (result[VEC_W-1:HALF_W] == '0));

        a_r6_no_result: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && size_code == 2'b11) |=> !out_valid);
    end else begin : g_comb
        assign out_valid = take_ok;
        assign undef     = take_rsv;
        assign result    = comb_res;
    end
endmodule

// File: tb/lsc_vec_top_tb_top.sv
`timescale 1ns/1ps
module lsc_vec_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] operand;
    logic [1:0]   size_code;
    logic         full_width;
    logic         out_valid;
    logic         undef;
    logic [127:0] result;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    lsc_vec_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .operand    (operand),
        .size_code  (size_code),
        .full_width (full_width),
        .out_valid  (out_valid),
        .undef      (undef),
        .result     (result)
    );

    localparam int NV = 13;
    localparam logic [127:0] T_OP [NV] = '{
        {16{8'h00}},
        {16{8'hFF}},
        {16{8'h80}},
        {16{8'h7F}},
        {16{8'h3C}},
        {8{16'h0001}},
        {8{16'hFFFF}},
        {4{32'hFFFF_8000}},
        {4{32'h0000_0000}},
        {16{8'h00}},
        {8{16'h8000}},
        {4{32'h00FF_0000}},
        {64'h0, 64'h0102_0408_1020_4080}
    };
    localparam logic [1:0] T_SZ [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0
    };
    localparam logic T_FW [NV] = '{
        1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1
    };
    localparam logic [127:0] T_EXP [NV] = '{
        {16{8'h07}},
        {16{8'h07}},
        128'h0,
        128'h0,
        {16{8'h01}},
        {8{16'h000E}},
        {8{16'h000F}},
        {4{32'h0000_0010}},
        {4{32'h0000_001F}},
        {64'h0, {8{8'h07}}},
        128'h0,
        {64'h0, {2{32'h0000_0007}}},
        {64'h0707_0707_0707_0707, 64'h0605_0403_0201_0000}
    };

    // Independent model: scan each lane from just under its top bit.
    function automatic logic [127:0] ref_model(logic [127:0] op, logic [1:0] sz, logic fw);
        logic [127:0] r = '0;
        int w  = 8 << sz;
        int dw = fw ? 128 : 64;
        for (int e = 0; e < dw / w; e++) begin
            int top = e * w + w - 1;
            int c   = 0;
            for (int b = top - 1; b >= e * w; b--) begin
                if (op[b] != op[top]) break;
                c++;
            end
            for (int k = 0; k < w; k++) begin
                r[e*w + k] = (k < 32) ? c[k] : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one strobe; on return, one posedge has passed (sampling at negedge).
    task automatic strobe(input logic [127:0] op, input logic [1:0] sz, input logic fw);
        @(negedge clk);
        in_valid   = 1'b1;
        operand    = op;
        size_code  = sz;
        full_width = fw;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] prev;
        logic [127:0] exp;
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        operand    = '0;
        size_code  = 2'b00;
        full_width = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!out_valid && !undef && result == '0, "R9 reset",
              {126'h0, out_valid, undef} | result, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !undef && result == '0, "R9 after reset",
              {126'h0, out_valid, undef} | result, 128'h0);

        // Table: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            strobe(T_OP[i], T_SZ[i], T_FW[i]);
            check(result == T_EXP[i], $sformatf("R1/R3/R4/R5 table %0d", i), result, T_EXP[i]);
            check(out_valid && !undef, "R7 valid after strobe", {126'h0, out_valid, undef}, 128'h2);
        end

        // R2: lane ordering with distinct 16-bit lanes, lane 0 at the bottom
        strobe({16'h0001, 16'h0002, 16'h0004, 16'h0008,
                16'h0010, 16'h0020, 16'h0040, 16'h0080}, 2'd1, 1'b1);
        exp = {16'd14, 16'd13, 16'd12, 16'd11, 16'd10, 16'd9, 16'd8, 16'd7};
        check(result == exp, "R2 lane order", result, exp);

        // R8: idle cycle drops valid, holds result
        prev = result;
        @(negedge clk);
        check(!out_valid && !undef, "R8 idle flags", {126'h0, out_valid, undef}, 128'h0);
        check(result == prev, "R8 idle hold", result, prev);

        // R6: reserved code
        strobe({4{32'h1234_5678}}, 2'b11, 1'b1);
        check(undef && !out_valid, "R6 undef flags", {126'h0, out_valid, undef}, 128'h1);
        check(result == prev, "R6 result held", result, prev);
        @(negedge clk);
        check(!undef && !out_valid, "R8 after undef", {126'h0, out_valid, undef}, 128'h0);

        // R7: back-to-back strobes, one-cycle latency each
        @(negedge clk);
        in_valid = 1'b1; operand = {16{8'hC0}}; size_code = 2'd0; full_width = 1'b1;
        @(negedge clk);
        check(out_valid && result == {16{8'h01}}, "R7 back-to-back first", result, {16{8'h01}});
        operand = {4{32'h0000_FFFF}}; size_code = 2'd2; full_width = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        exp = {64'h0, {2{32'h0000_000F}}};
        check(out_valid && result == exp, "R7/R5 back-to-back second", result, exp);

        // Random and corner-biased: R1 R3 R5 R6 R7
        for (int n = 0; n < 400; n++) begin
            logic [127:0] op;
            logic [1:0]   sz;
            logic         fw;
            op = {$urandom, $urandom, $urandom, $urandom};
            case ($urandom % 6)
                0: op = '0;
                1: op = '1;
                2: op = op >> ($urandom % 128);
                3: op = ~(op >> ($urandom % 128));
                default: ;
            endcase
            sz   = 2'($urandom % 4);
            fw   = 1'($urandom % 2);
            prev = result;
            strobe(op, sz, fw);
            if (sz == 2'b11) begin
                check(undef && !out_valid && result == prev, "R6 random reserved", result, prev);
            end else begin
                exp = ref_model(op, sz, fw);
                check(out_valid && !undef && result == exp, "R1/R7 random", result, exp);
            end
        end

        // R9: reset mid-operation clears the outputs
        strobe({16{8'h00}}, 2'd0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && !undef && result == '0, "R9 re-reset", result, 128'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule